// File: doc/BRIEF.md
# Bus Stability Window Monitor

This block watches a data bus during a window. A start strobe opens the window and an end strobe closes it. On the opening edge the monitor stores the bus value as a reference. On every later evaluated edge inside the window it compares the bus with that reference, including the edge that closes the window. Each edge where the bus differs from the reference produces a one-cycle fail pulse. A window that closes with no mismatch produces one pass pulse, however many cycles it lasted. Two saturating counters hold the number of pass and fail pulses.

Only clock edges where the enable input is high are evaluated. A window can open and close on the same edge, and a new window can open on the edge right after the previous one closed. A static restart-mode input selects how a start strobe inside an open window is handled. With the mode off, that start is ignored. With the mode on, the start abandons the current window and opens a new one with a fresh reference.

Top module: `stab_window_monitor`

## Requirements
- R1: A synchronous active-high reset closes any open window and clears pass_o, fail_o, pass_cnt_o and fail_cnt_o to zero.
- R2: A window opens on an enabled rising edge with start_i high while no window is open, and data_i at that edge becomes the reference.
- R3: At every enabled edge inside an open window, including the closing edge, data_i is compared with the reference. Each mismatching edge gives its own fail_o pulse, one cycle wide, in the cycle after that edge.
- R4: An open window closes on the first later enabled edge with end_i high. If no edge in the window mismatched, pass_o pulses once, one cycle wide, in the cycle after the closing edge. A mismatch does not close the window early, and pass_o and fail_o are never high together.
- R5: Edges with en_i low do not open a window, close it or compare data, and they produce no pulse.
- R6: start_i and end_i high together on an enabled edge while no window is open give a one-cycle window, and pass_o pulses after that edge.
- R7: A start on the enabled edge right after a closing edge opens a new window with a new reference.
- R8: With restart_i low, start_i inside an open window is ignored and the original reference is kept.
- R9: With restart_i high, start_i inside an open window abandons it without a pass pulse and without a comparison on that edge, then opens a new window with data_i as the reference. If end_i is also high on that edge, the new window is a one-cycle window. An end strobe before any second start closes the window normally.
- R10: pass_cnt_o and fail_cnt_o each rise by one in the cycle their pulse is high, and they hold at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Edge qualifier; low edges are skipped |
| start_i | input | 1 | Window open strobe |
| end_i | input | 1 | Window close strobe |
| restart_i | input | 1 | Static mode: a start inside a window restarts it |
| data_i | input | DATA_W | Watched bus |
| pass_o | output | 1 | One-cycle pulse for a window closed without mismatch |
| fail_o | output | 1 | One-cycle pulse per mismatching edge |
| pass_cnt_o | output | CNT_W | Saturating pass count |
| fail_cnt_o | output | CNT_W | Saturating fail count |

## Verification
The hardest cases to reach are the edges where several events meet: a start and an end on one edge while a window is open, a restart on the closing edge, and a mismatch on the edge that ends the window. Purely random strobes hit these only rarely. The bench therefore drives directed sequences for each of them, then runs a long random phase. In that phase the strobes are dense and the bus changes only occasionally, so windows both pass and fail, and restart mode is toggled between blocks. The counter width is reduced so that saturation is reached.

// File: rtl/stab_pkg.sv
package stab_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  localparam int unsigned EVT_PASS = 0;
  localparam int unsigned EVT_FAIL = 1;
  localparam int unsigned EVT_NUM  = 2;

endpackage

// File: rtl/stab_ref_capture.sv
module stab_ref_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              mismatch_o
);

  logic [DATA_W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
    end else if (load_i) begin
      ref_q <= data_i;
    end
  end

  assign mismatch_o = (data_i != ref_q);

endmodule

// File: rtl/stab_window_ctrl.sv
module stab_window_ctrl
  import stab_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic start_i,
  input  logic end_i,
  input  logic restart_i,
  input  logic mismatch_i,
  output logic load_o,
  output logic pass_evt_o,
  output logic fail_evt_o
);

  win_state_e state_q;
  logic       err_q;
  logic       is_open;
  logic       take_start;
  logic       compare;

  assign is_open    = (state_q == WIN_OPEN);
  // a start counts when the window is closed, or when restarting is allowed
  assign take_start = en_i && start_i && (!is_open || restart_i);
  // a restart edge abandons the old window and is not compared
  assign compare    = en_i && is_open && !take_start;

  assign load_o     = take_start;
  assign fail_evt_o = compare && mismatch_i;
  assign pass_evt_o = (take_start && end_i) ||
                      (compare && end_i && !err_q && !mismatch_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WIN_IDLE;
      err_q   <= 1'b0;
    end else if (take_start) begin
      state_q <= end_i ? WIN_IDLE : WIN_OPEN;
      err_q   <= 1'b0;
    end else if (compare) begin
      if (end_i) begin
        state_q <= WIN_IDLE;
        err_q   <= 1'b0;
      end else if (mismatch_i) begin
        err_q   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/stab_sat_counter.sv
module stab_sat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (inc_i && (cnt_o != CNT_MAX)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/stab_window_monitor.sv
module stab_window_monitor
  import stab_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              end_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pass_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  pass_cnt_o,
  output logic [CNT_W-1:0]  fail_cnt_o
);

  logic               load;
  logic               mismatch;
  logic [EVT_NUM-1:0] evt;
  logic [EVT_NUM-1:0] pulse_q;
  logic [CNT_W-1:0]   cnt [EVT_NUM];

  stab_ref_capture #(.DATA_W(DATA_W)) u_ref (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .data_i    (data_i),
    .mismatch_o(mismatch)
  );

  stab_window_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .start_i   (start_i),
    .end_i     (end_i),
    .restart_i (restart_i),
    .mismatch_i(mismatch),
    .load_o    (load),
    .pass_evt_o(evt[EVT_PASS]),
    .fail_evt_o(evt[EVT_FAIL])
  );

  for (genvar g = 0; g < EVT_NUM; g++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst) pulse_q[g] <= 1'b0;
      else     pulse_q[g] <= evt[g];
    end

    stab_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .inc_i(evt[g]),
      .cnt_o(cnt[g])
    );
  end

  assign pass_o     = pulse_q[EVT_PASS];
  assign fail_o     = pulse_q[EVT_FAIL];
  assign pass_cnt_o = cnt[EVT_PASS];
  assign fail_cnt_o = cnt[EVT_FAIL];

endmodule

// File: rtl/stab_window_monitor_chk.sv
module stab_window_monitor_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              start_i,
  input logic              end_i,
  input logic              restart_i,
  input logic [DATA_W-1:0] data_i,
  input logic              pass_o,
  input logic              fail_o,
  input logic [CNT_W-1:0]  pass_cnt_o,
  input logic [CNT_W-1:0]  fail_cnt_o
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_no_dual_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o));

  assert_idle_edge_silent_R5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!pass_o && !fail_o));

  assert_restart_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    (en_i && start_i && end_i && restart_i) |=> pass_o);

  assert_fail_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && fail_o && $past(fail_cnt_o) != CMAX)
      |-> fail_cnt_o == $past(fail_cnt_o) + 1'b1);

  assert_pass_count_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !pass_o) |-> pass_cnt_o == $past(pass_cnt_o));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fail_cnt_o) == CMAX) |-> fail_cnt_o == CMAX);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!pass_o && !fail_o && pass_cnt_o == '0 && fail_cnt_o == '0));

endmodule

bind stab_window_monitor stab_window_monitor_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/test_stab_window_monitor.sv
`timescale 1ns/1ps
module test_stab_window_monitor;

  localparam int DW = 8;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, st = 1'b0, nd = 1'b0, rm = 1'b0;
  logic [DW-1:0] data = '0;
  logic pass_o, fail_o;
  logic [CW-1:0] pass_cnt_o, fail_cnt_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // bench model
  bit m_open = 0, m_err = 0;
  logic [DW-1:0] m_ref = '0;
  bit e_pass = 0, e_fail = 0;
  int e_pcnt = 0, e_fcnt = 0;

  always #4 clk = ~clk;

  stab_window_monitor #(.DATA_W(DW), .CNT_W(CW)) i_stab_window_monitor (
    .clk(clk), .rst(rst), .en_i(en), .start_i(st), .end_i(nd),
    .restart_i(rm), .data_i(data), .pass_o(pass_o), .fail_o(fail_o),
    .pass_cnt_o(pass_cnt_o), .fail_cnt_o(fail_cnt_o)
  );

  // expected {pass,fail} of one evaluated edge
  function automatic logic [1:0] eval_edge(bit o, bit er, logic [DW-1:0] rf,
      bit e, bit s, bit n, bit r, logic [DW-1:0] d);
    bit acc = e && s && (!o || r);
    bit cmp = e && o && !acc;
    bit f = cmp && (d != rf);
    bit p = (acc && n) || (cmp && n && !er && !f);
    return {p, f};
  endfunction

  function automatic int sat_inc(int v, bit inc);
    return (inc && v < CMAX) ? v + 1 : v;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    chk(tag, "pass_o", int'(pass_o), int'(e_pass));
    chk(tag, "fail_o", int'(fail_o), int'(e_fail));
    chk("R10", "pass_cnt_o", int'(pass_cnt_o), e_pcnt);
    chk("R10", "fail_cnt_o", int'(fail_cnt_o), e_fcnt);
  endtask

  // at a falling edge: check the previous edge's result, then drive the next
  task automatic step(string tag, bit e, bit s, bit n, bit r, logic [DW-1:0] d);
    logic [1:0] pf;
    bit acc, cmp;
    @(negedge clk);
    check_outputs(tag);
    pf  = eval_edge(m_open, m_err, m_ref, e, s, n, r, d);
    acc = e && s && (!m_open || r);
    cmp = e && m_open && !acc;
    if (acc) begin
      m_ref = d; m_err = 0; m_open = !n;
    end else if (cmp) begin
      if (n) begin m_open = 0; m_err = 0; end
      else if (pf[0]) m_err = 1;
    end
    e_pass = pf[1]; e_fail = pf[0];
    e_pcnt = sat_inc(e_pcnt, pf[1]);
    e_fcnt = sat_inc(e_fcnt, pf[0]);
    en = e; st = s; nd = n; rm = r; data = d; rst = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 0; st = 0; nd = 0;
    m_open = 0; m_err = 0; m_ref = '0;
    e_pass = 0; e_fail = 0; e_pcnt = 0; e_fcnt = 0;
    @(negedge clk);
    @(negedge clk);
    check_outputs("R1");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R2 R4: plain window that passes
    step("R2", 1, 1, 0, 0, 8'h5A);
    step("R4", 1, 0, 0, 0, 8'h5A);
    step("R4", 1, 0, 1, 0, 8'h5A);
    step("R4", 0, 0, 0, 0, 8'h00);
    // R3: two mismatches, window stays open, mismatch on closing edge
    step("R3", 1, 1, 0, 0, 8'h11);
    step("R3", 1, 0, 0, 0, 8'h12);
    step("R3", 1, 0, 0, 0, 8'h11);
    step("R3", 1, 0, 0, 0, 8'h13);
    step("R3", 1, 0, 1, 0, 8'h14);
    step("R3", 0, 0, 0, 0, 8'h00);
    // R5: disabled edges with mismatch, start and end ignored
    step("R5", 1, 1, 0, 0, 8'h22);
    step("R5", 0, 0, 1, 0, 8'h99);
    step("R5", 0, 1, 1, 0, 8'h77);
    step("R5", 1, 0, 1, 0, 8'h22);
    step("R5", 0, 1, 0, 0, 8'h00);
    step("R5", 0, 0, 0, 0, 8'h00);
    // R6: one-cycle window
    step("R6", 1, 1, 1, 0, 8'h33);
    step("R6", 0, 0, 0, 0, 8'h00);
    // R7: back-to-back windows with different references
    step("R7", 1, 1, 0, 0, 8'h40);
    step("R7", 1, 0, 1, 0, 8'h40);
    step("R7", 1, 1, 0, 0, 8'h41);
    step("R7", 1, 0, 1, 0, 8'h41);
    step("R7", 0, 0, 0, 0, 8'h00);
    // R8: restart off, second start with new data keeps old reference
    step("R8", 1, 1, 0, 0, 8'h50);
    step("R8", 1, 1, 0, 0, 8'h51);
    step("R8", 1, 0, 1, 0, 8'h51);
    step("R8", 0, 0, 0, 0, 8'h00);
    // R9: restart on, new reference, then restart together with end
    step("R9", 1, 1, 0, 1, 8'h60);
    step("R9", 1, 1, 0, 1, 8'h61);
    step("R9", 1, 0, 0, 1, 8'h61);
    step("R9", 1, 1, 1, 1, 8'h62);
    step("R9", 1, 1, 0, 1, 8'h63);
    step("R9", 1, 0, 1, 1, 8'h63);
    step("R9", 0, 0, 0, 1, 8'h00);
    // R10: drive counters into saturation
    step("R10", 1, 1, 0, 0, 8'h00);
    for (int i = 0; i < 20; i++) step("R10", 1, 0, 0, 0, 8'h01);
    step("R10", 1, 0, 1, 0, 8'h00);
    for (int i = 0; i < 20; i++) step("R10", 1, 1, 1, 0, 8'h07);
    step("R10", 0, 0, 0, 0, 8'h00);
    // R1: reset mid-window clears everything
    step("R1", 1, 1, 0, 0, 8'hAA);
    do_reset();
    step("R1", 1, 0, 1, 0, 8'hBB);
    step("R1", 0, 0, 0, 0, 8'h00);
    // random phase
    for (int blk = 0; blk < 40; blk++) begin
      bit r = ($urandom % 2) == 1;
      if (blk % 8 == 0) do_reset();
      for (int i = 0; i < 200; i++) begin
        bit e = ($urandom % 5) != 0;
        bit s = ($urandom % 4) == 0;
        bit n = ($urandom % 4) == 0;
        logic [DW-1:0] d = (($urandom % 8) == 0) ? DW'($urandom) : data;
        step("R3", e, s, n, r, d);
      end
    end
    step("R4", 0, 0, 0, 0, 8'h00);
    @(negedge clk);
    check_outputs("R4");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule